// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Counter Bank

This block holds a bank of 64-bit down-counters behind a small register interface with single-cycle reads and writes. Each counter has a control word and a count value split into low and high 32-bit words. A counter can run once from its loaded value down to zero. It can also wait for a hardware event, the expiry of the counter just below it, and then reload its programmed start value and count down again. A one-hot select register names the counter that acts as the watchdog. When that counter expires, the block raises a one-cycle reset request.

The usual set-up uses two counters. The watchdog counter waits in hardware-trigger mode. The counter below it is a one-shot with a count of zero. Enabling that lower counter makes it expire at once, and its expiry reloads the watchdog. Software therefore keeps the system alive by clearing and then setting the lower counter's enable bit. The watchdog never stops during a kick. A read of a low count word captures the matching high word, so a 64-bit value read in two accesses is consistent even while the counter runs.

Top module: `ctr_chain_wdog`

## Requirements
- R1: Counter n's registers sit at byte offset n*0x10: +0x0 control, +0x4 count bits [31:0], +0x8 count bits [63:32]. The select register is at 0x40. Control layout: bit 0 enable, bit 1 active (read-only, writes ignored), bits [3:2] mode (00 one-shot, 11 hardware trigger), bits [7:4] trigger source, bits [15:8] divide value, other bits read 0. Any other address, and any unaligned address, reads 0 and ignores writes. Reads return data one cycle after the access.
- R2: A write to a count word sets that half of both the reload value and the live count.
- R3: An active counter decrements once every D clock cycles, where D is the divide field; a divide value below 2 acts as 2.
- R4: Setting enable on a one-shot counter (enable written 1 while it was 0) makes it active. An active counter at zero expires on the next edge: it pulses its end event and goes inactive. The count never wraps below zero.
- R5: A counter in hardware-trigger mode with trigger source 5 reloads its start value and becomes active when counter n-1 expires. Setting its enable bit alone does not activate it.
- R6: Reading the low count word captures the high 32 bits of the count at that moment. The next high-word read returns the captured value, not the live value.
- R7: When the counter chosen by the one-hot select register expires, wdt_reset_o is high for exactly one cycle. Select value 0 chooses no counter, and an unselected counter's expiry never raises the output.
- R8: After it expires, a counter stays inactive at count zero until it is triggered or re-enabled.
- R9: Clearing enable freezes the count and clears active.
- R10: Counter 0 has no lower neighbour, so hardware-trigger mode with source 5 never activates it.
- R11: With counter 0 as a one-shot at zero feeding counter 1, wdt_reset_o goes high after 3 + D*N rising edges, counted from the edge that writes counter 0's enable bit from 0 to 1. N is counter 1's reload value. The same holds for a kick while counter 1 is still running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| wdt_reset_o | output | 1 | One-cycle reset request from the selected counter |

## Verification
The bench builds the block with its default parameters: four counters, an 8-bit address and an 8-bit divide field. These defaults bring into reach the counter-0 chain boundary, the select register above the counter groups, and divide values below the legal minimum. Random reload and divide pairs check the exact expiry latency through the counter-0 to counter-1 chain. Random kick points confirm that a kick restarts the window with no gap. Directed cases cover coherent 64-bit reads across a borrow from the high word, freezing on disable, and expiry of unselected counters.

// File: rtl/ccw_pkg.sv
// Shared constants and types for the chained watchdog counter bank.
// Assumes a 32-bit data path and counts of twice that width.
package ccw_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 2 * DATA_W;
    localparam int GRP_SHIFT = 4;      // each counter group spans 16 bytes
    localparam int PRESC_MIN = 2;

    localparam logic [1:0] MODE_ONESHOT = 2'b00;
    localparam logic [1:0] MODE_HWTRIG  = 2'b11;
    localparam logic [3:0] TRIG_PREV    = 4'd5;

    // Word selector inside a counter group (address bits [3:2])
    typedef enum logic [1:0] {
        W_CTRL = 2'd0,
        W_LO   = 2'd1,
        W_HI   = 2'd2,
        W_NONE = 2'd3
    } word_e;
endpackage

// File: rtl/ccw_decode.sv
// Address decoder: turns one bus access into per-counter strobes.
// Assumes word-aligned addresses; an unaligned access matches nothing.
module ccw_decode
    import ccw_pkg::*;
#(
    parameter int NUM_CNT  = 4,
    parameter int ADDR_W   = 8,
    parameter int SEL_ADDR = 'h40,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    output logic [NUM_CNT-1:0] wr_ctrl,
    output logic [NUM_CNT-1:0] wr_lo,
    output logic [NUM_CNT-1:0] wr_hi,
    output logic [NUM_CNT-1:0] rd_lo,
    output logic               wr_sel,
    output logic               grp_hit,
    output logic               sel_hit,
    output logic [IDX_W-1:0]   grp_idx,
    output word_e              word
);
    localparam int GRP_W = ADDR_W - GRP_SHIFT;
    localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);

    logic [GRP_W-1:0] grp;

    // Split the address into group, word and alignment checks
    always_comb begin
        grp     = addr[ADDR_W-1:GRP_SHIFT];
        word    = word_e'(addr[3:2]);
        grp_hit = (int'(grp) < NUM_CNT) && (addr[1:0] == 2'b00);
        grp_idx = grp[IDX_W-1:0];
        sel_hit = (addr == SEL_A);
        wr_sel  = wr_en && sel_hit;
    end

    // Produce one strobe per counter and word
    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) begin
            wr_ctrl[n] = wr_en && grp_hit && (int'(grp) == n) && (word == W_CTRL);
            wr_lo[n]   = wr_en && grp_hit && (int'(grp) == n) && (word == W_LO);
            wr_hi[n]   = wr_en && grp_hit && (int'(grp) == n) && (word == W_HI);
            rd_lo[n]   = rd_en && grp_hit && (int'(grp) == n) && (word == W_LO);
        end
    end
endmodule

// File: rtl/ccw_counter.sv
// One 64-bit down-counter with prescaler, one-shot and hardware-trigger
// modes, end-count pulse and a high-word holding register for reads.
// Assumes at most one register write per cycle; a write beats a trigger.
module ccw_counter
    import ccw_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trig_in,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [DATA_W-1:0] hold_o,
    output logic              end_o
);
    logic              en_q, active_q, end_q;
    logic [1:0]        mode_q;
    logic [3:0]        trig_q;
    logic [DIV_W-1:0]  div_q, pc_q, div_eff;
    logic [CNT_W-1:0]  reload_q, count_q;
    logic [DATA_W-1:0] hold_q;
    logic              tick, trig_fire;

    // Effective divide value and the decrement and trigger conditions
    always_comb begin
        div_eff   = (div_q < DIV_W'(PRESC_MIN)) ? DIV_W'(PRESC_MIN) : div_q;
        tick      = (pc_q == div_eff - 1'b1);
        trig_fire = en_q && (mode_q == MODE_HWTRIG) && (trig_q == TRIG_PREV) && trig_in;
    end

    // Control, reload, countdown and end-event state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            active_q <= 1'b0;
            end_q    <= 1'b0;
            mode_q   <= MODE_ONESHOT;
            trig_q   <= '0;
            div_q    <= '0;
            pc_q     <= '0;
            reload_q <= '0;
            count_q  <= '0;
        end else begin
            end_q <= 1'b0;
            if (wr_ctrl) begin
                en_q   <= wdata[0];
                mode_q <= wdata[3:2];
                trig_q <= wdata[7:4];
                div_q  <= wdata[8 +: DIV_W];
                if (!wdata[0]) begin
                    active_q <= 1'b0;
                end else if (!en_q && wdata[3:2] == MODE_ONESHOT) begin
                    active_q <= 1'b1;
                    pc_q     <= '0;
                end
            end else if (wr_lo || wr_hi) begin
                if (wr_lo) begin
                    reload_q[DATA_W-1:0] <= wdata;
                    count_q[DATA_W-1:0]  <= wdata;
                end else begin
                    reload_q[CNT_W-1:DATA_W] <= wdata;
                    count_q[CNT_W-1:DATA_W]  <= wdata;
                end
                pc_q <= '0;
            end else if (trig_fire) begin
                count_q  <= reload_q;
                active_q <= 1'b1;
                pc_q     <= '0;
            end else if (en_q && active_q) begin
                if (count_q == '0) begin
                    end_q    <= 1'b1;
                    active_q <= 1'b0;
                end else if (tick) begin
                    count_q <= count_q - 1'b1;
                    pc_q    <= '0;
                end else begin
                    pc_q <= pc_q + 1'b1;
                end
            end
        end
    end

    // Capture the high word when the low word is read
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (rd_lo) hold_q <= count_q[CNT_W-1:DATA_W];
    end

    assign ctrl_o  = DATA_W'({div_q, trig_q, mode_q, active_q, en_q});
    assign count_o = count_q;
    assign hold_o  = hold_q;
    assign end_o   = end_q;
endmodule

// File: rtl/ccw_readback.sv
// Registered read multiplexer over control words, live low words, held
// high words and the select register. Assumes decoded inputs from ccw_decode.
module ccw_readback
    import ccw_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int IDX_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic                            grp_hit,
    input  logic                            sel_hit,
    input  logic [IDX_W-1:0]                grp_idx,
    input  word_e                           word,
    input  logic [NUM_CNT-1:0][DATA_W-1:0]  ctrl_v,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   count_v,
    input  logic [NUM_CNT-1:0][DATA_W-1:0]  hold_v,
    input  logic [NUM_CNT-1:0]              sel_v,
    output logic [DATA_W-1:0]               rdata
);
    logic [DATA_W-1:0] mux;

    // Pick the word addressed by the current read
    always_comb begin
        mux = '0;
        if (grp_hit) begin
            case (word)
                W_CTRL:  mux = ctrl_v[grp_idx];
                W_LO:    mux = count_v[grp_idx][DATA_W-1:0];
                W_HI:    mux = hold_v[grp_idx];
                default: mux = '0;
            endcase
        end else if (sel_hit) begin
            mux = DATA_W'(sel_v);
        end
    end

    // Register read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mux;
    end
endmodule

// File: rtl/ctr_chain_wdog.sv
// Top of the chained watchdog counter bank: decoder, counter array with
// neighbour chaining, watchdog select register and read path.
// Assumes the select register holds a one-hot or zero value.
module ctr_chain_wdog
    import ccw_pkg::*;
#(
    parameter int NUM_CNT  = 4,
    parameter int ADDR_W   = 8,
    parameter int DIV_W    = 8,
    parameter int SEL_ADDR = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              wdt_reset_o
);
    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    logic [NUM_CNT-1:0]              wr_ctrl, wr_lo, wr_hi, rd_lo;
    logic [NUM_CNT-1:0]              end_v, trig_in;
    logic [NUM_CNT-1:0][DATA_W-1:0]  ctrl_v, hold_v;
    logic [NUM_CNT-1:0][CNT_W-1:0]   count_v;
    logic [NUM_CNT-1:0]              sel_q;
    logic                            wr_sel, grp_hit, sel_hit;
    logic [IDX_W-1:0]                grp_idx;
    word_e                           word;

    ccw_decode #(
        .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .IDX_W(IDX_W)
    ) u_dec (
        .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
        .wr_ctrl(wr_ctrl), .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo),
        .wr_sel(wr_sel), .grp_hit(grp_hit), .sel_hit(sel_hit),
        .grp_idx(grp_idx), .word(word)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        if (n == 0) begin : g_first
            assign trig_in[n] = 1'b0;            // no lower neighbour
        end else begin : g_chain
            assign trig_in[n] = end_v[n-1];
        end

        ccw_counter #(.DIV_W(DIV_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .wr_ctrl(wr_ctrl[n]), .wr_lo(wr_lo[n]), .wr_hi(wr_hi[n]),
            .rd_lo(rd_lo[n]), .wdata(bus_wdata), .trig_in(trig_in[n]),
            .ctrl_o(ctrl_v[n]), .count_o(count_v[n]), .hold_o(hold_v[n]),
            .end_o(end_v[n])
        );
    end

    // Watchdog select register
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= bus_wdata[NUM_CNT-1:0];
    end

    assign wdt_reset_o = |(end_v & sel_q);

    ccw_readback #(.NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_rb (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd),
        .grp_hit(grp_hit), .sel_hit(sel_hit), .grp_idx(grp_idx), .word(word),
        .ctrl_v(ctrl_v), .count_v(count_v), .hold_v(hold_v), .sel_v(sel_q),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/ccw_checker.sv
// Property checker for ctr_chain_wdog, attached by bind below.
module ccw_checker
    import ccw_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CNT-1:0][DATA_W-1:0]  ctrl_v,
    input logic [NUM_CNT-1:0][CNT_W-1:0]   count_v,
    input logic [NUM_CNT-1:0]              end_v,
    input logic [NUM_CNT-1:0]              trig_in,
    input logic [NUM_CNT-1:0]              wr_ctrl,
    input logic [NUM_CNT-1:0]              wr_lo,
    input logic [NUM_CNT-1:0]              wr_hi,
    input logic [NUM_CNT-1:0]              sel_v,
    input logic                            wdt_reset_o
);
    logic [NUM_CNT-1:0] act_v;
    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) act_v[n] = ctrl_v[n][1];
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
        assert_active_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_v[n][1] |-> ctrl_v[n][0]);

        assert_disable_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_v[n][0] && !wr_lo[n] && !wr_hi[n]) |=> $stable(count_v[n]));

        assert_zero_expires_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_v[n][1] && count_v[n] == '0 && !wr_ctrl[n] && !wr_lo[n] && !wr_hi[n]
             && !(ctrl_v[n][3:2] == MODE_HWTRIG && ctrl_v[n][7:4] == TRIG_PREV && trig_in[n]))
            |=> (end_v[n] && !ctrl_v[n][1] && count_v[n] == '0));

        assert_end_leaves_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            end_v[n] |-> !ctrl_v[n][1]);
    end

    assert_first_never_chained_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_v[0][3:2] == MODE_HWTRIG && !ctrl_v[0][1] && !wr_ctrl[0]) |=> !ctrl_v[0][1]);

    assert_reset_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset_o && $onehot0(sel_v)) |=> !wdt_reset_o);

    assert_reset_from_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset_o && $stable(sel_v)) |-> $past(|(act_v & sel_v)));
endmodule

bind ctr_chain_wdog ccw_checker #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_v(ctrl_v), .count_v(count_v),
    .end_v(end_v), .trig_in(trig_in), .wr_ctrl(wr_ctrl), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .sel_v(sel_q), .wdt_reset_o(wdt_reset_o)
);

// File: tb/ctr_chain_wdog_test.sv
module ctr_chain_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ctr_chain_wdog uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .wdt_reset_o(wdt_reset_o)
    );

    // Expected expiry latency through the counter-0 to counter-1 chain
    function automatic int exp_latency(input int div, input int n);
        int d;
        d = (div < 2) ? 2 : div;
        return 3 + d * n;
    endfunction

    function automatic logic [31:0] ctrl_word(input int div, input int trig,
                                              input int mode, input bit en);
        return (32'(div) << 8) | (32'(trig) << 4) | (32'(mode) << 2) | 32'(en);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_reset(output int lat);
        lat = 0;
        while (!wdt_reset_o && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic idle_no_reset(input int cycles, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (wdt_reset_o) seen = 1;
            @(negedge clk);
        end
        check(tag, 32'(seen), 32'd0);
    endtask

    task automatic kick0();
        bus_write(8'h00, 32'h0);
        bus_write(8'h00, ctrl_word(0, 0, 0, 1'b1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, d2;
        int lat;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1 reset output", 32'(wdt_reset_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and address map
        bus_read(8'h00, d); check("R1 ctrl0 reset", d, 32'h0);
        bus_read(8'h40, d); check("R1 select reset", d, 32'h0);
        bus_read(8'h14, d); check("R1 count1 low reset", d, 32'h0);

        // R2: count words write both halves
        bus_write(8'h24, 32'hA5A5_0001);
        bus_write(8'h28, 32'h1234_5678);
        bus_read(8'h24, d); check("R2 count2 low", d, 32'hA5A5_0001);
        bus_read(8'h28, d); check("R2 count2 high", d, 32'h1234_5678);
        bus_read(8'h2C, d); check("R1 unmapped word", d, 32'h0);
        bus_read(8'h50, d); check("R1 unmapped group", d, 32'h0);
        bus_read(8'h26, d); check("R1 unaligned", d, 32'h0);

        // R1: control fields, active bit read-only
        bus_write(8'h20, 32'hFFFF_03F6);
        bus_read(8'h20, d); check("R1 ctrl fields", d, 32'h0000_03F4);

        // R6: coherent read across a borrow from the high word
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'h1);
        bus_write(8'h20, ctrl_word(2, 0, 0, 1'b1));
        bus_read(8'h24, d); check("R6 low before borrow", d, 32'h0);
        bus_read(8'h28, d); check("R6 held high", d, 32'h1);
        bus_read(8'h24, d); check("R6 low after borrow", d, 32'hFFFF_FFFF);
        bus_read(8'h28, d); check("R6 high after borrow", d, 32'h0);

        // R9: disable freezes count and clears active
        bus_write(8'h20, ctrl_word(2, 0, 0, 1'b0));
        bus_read(8'h24, d);
        repeat (10) @(negedge clk);
        bus_read(8'h24, d2); check("R9 frozen count", d2, d);
        bus_read(8'h20, d); check("R9 ctrl inactive", d, ctrl_word(2, 0, 0, 1'b0));

        // R4/R8: one-shot runs to zero and stops without wrapping
        bus_write(8'h24, 32'd3);
        bus_write(8'h28, 32'h0);
        bus_write(8'h20, ctrl_word(2, 0, 0, 1'b1));
        repeat (20) @(negedge clk);
        bus_read(8'h24, d); check("R4 one-shot low at zero", d, 32'h0);
        bus_read(8'h28, d); check("R4 one-shot high no wrap", d, 32'h0);
        bus_read(8'h20, d); check("R8 one-shot idle", d, ctrl_word(2, 0, 0, 1'b1));

        // R10: counter 0 in chained mode never starts
        bus_write(8'h30, ctrl_word(2, 0, 0, 1'b1));   // counter 3 expires at once
        bus_write(8'h00, ctrl_word(2, 5, 3, 1'b1));
        repeat (10) @(negedge clk);
        bus_read(8'h00, d); check("R10 counter0 stays inactive", d, ctrl_word(2, 5, 3, 1'b1));
        bus_write(8'h00, 32'h0);

        // R5: enable alone does not start a chained counter
        bus_write(8'h14, 32'd5);
        bus_write(8'h18, 32'h0);
        bus_write(8'h10, ctrl_word(2, 5, 3, 1'b1));
        repeat (10) @(negedge clk);
        bus_read(8'h14, d); check("R5 count unchanged", d, 32'd5);
        bus_read(8'h10, d); check("R5 not active", d, ctrl_word(2, 5, 3, 1'b1));

        // R7: no select, no reset; R8: chained counter expires and idles
        bus_write(8'h00, ctrl_word(0, 0, 0, 1'b1));
        idle_no_reset(40, "R7 unselected expiry");
        bus_read(8'h14, d); check("R8 expired count zero", d, 32'h0);
        bus_read(8'h10, d); check("R8 expired idle", d, ctrl_word(2, 5, 3, 1'b1));

        // R7: select counter 1
        bus_write(8'h40, 32'h2);
        bus_read(8'h40, d); check("R7 select readback", d, 32'h2);

        // R3/R11: random reload and divide values
        for (int it = 0; it < 20; it++) begin
            int n, p;
            n = $urandom_range(1, 30);
            p = $urandom_range(0, 6);
            bus_write(8'h14, 32'(n));
            bus_write(8'h18, 32'h0);
            bus_write(8'h10, ctrl_word(p, 5, 3, 1'b1));
            kick0();
            wait_reset(lat);
            check("R11 R3 expiry latency", 32'(lat), 32'(exp_latency(p, n)));
            @(negedge clk);
            check("R7 single-cycle pulse", 32'(wdt_reset_o), 32'd0);
            repeat (3) @(negedge clk);
            bus_read(8'h10, d); check("R8 idle after expiry", d, ctrl_word(p, 5, 3, 1'b1));
        end

        // R11: kicks while running restart the window
        for (int it = 0; it < 6; it++) begin
            int n, p, k;
            n = $urandom_range(10, 25);
            p = $urandom_range(2, 4);
            k = $urandom_range(4, p * n - 4);
            bus_write(8'h14, 32'(n));
            bus_write(8'h10, ctrl_word(p, 5, 3, 1'b1));
            kick0();
            idle_no_reset(k, "R11 no reset before kick");
            kick0();
            wait_reset(lat);
            check("R11 latency after kick", 32'(lat), 32'(exp_latency(p, n)));
            repeat (4) @(negedge clk);
        end

        // R7: another counter selected, counter 1 expiry ignored
        bus_write(8'h40, 32'h4);
        bus_write(8'h14, 32'd4);
        kick0();
        idle_no_reset(30, "R7 other counter selected");
        bus_write(8'h40, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule